// File: doc/BRIEF.md
# Selectable Pixel Clock Enable Generator

This block derives a pixel-clock enable from one fast reference clock. A 3-bit select code picks one of eight nominal dot-clock frequencies. A fractional phase accumulator sized from the reference frequency produces that rate. A post-divider then scales the result by 1, 1.5, 2 or 4. Downstream video timing logic runs from the reference clock and advances one pixel on each cycle where the enable is high.

The select code is split across two register sources. The two clock-select bits of the miscellaneous output register supply the low bits. One bit of an extended graphics register supplies the high bit, and the same register carries the 2-bit divider code. The block also decodes one extended CRTC register byte into an interlace flag and the high display start-address bits. A change to the select code or the divider code takes effect only at an enable boundary, so no period is ever shortened.

Top module: `pclk_gen_top`

## Requirements
- R1: The active select code is `{ext_clk_sel_i, misc_clk_sel_i[1:0]}`, so `ext_clk_sel_i` is bit 2 and `misc_clk_sel_i` supplies bits 1:0.
- R2: Select codes 2, 3, 4, 5, 6 and 7 produce 36, 65.1, 44.9, 50, 80 and 75 MHz. Over a 4000-cycle window, the count of enables after the post-divider is within ±2 of the ideal count.
- R3: Select codes 0 and 1 produce the two standard VGA dot clocks, 25.175 MHz and 28.322 MHz, with the same ±2 tolerance.
- R4: `div_code_i` divides the selected rate: 0 gives ÷1, 1 gives ÷1.5, 2 gives ÷2 and 3 gives ÷4.
- R5: In ÷1.5 mode, exactly 2 of every 3 undivided enables pass, giving alternating gaps.
- R6: A new divider code is adopted only when a complete divider group has finished, and a new increment only on an accumulator overflow. `pix_en_o` is never high on two consecutive cycles.
- R7: `interlace_o` equals bit 0 of `crtc_ext_i` as sampled on the previous clock edge.
- R8: `start_addr_hi_o` carries start-address bits 23:20. Bit 23 comes from `crtc_ext_i` bit 6, bit 20 from bit 4, and bits 22:21 are zero. It has the same one-cycle latency as R7.
- R9: While `rst_n` is low at a clock edge, `pix_en_o`, `interlace_o` and `start_addr_hi_o` are zero on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| misc_clk_sel_i | input | 2 | Clock-select bits from the miscellaneous output register |
| ext_clk_sel_i | input | 1 | Extended clock-select bit (select bit 2) |
| div_code_i | input | 2 | Post-divider code |
| crtc_ext_i | input | 8 | Extended CRTC register byte |
| pix_en_o | output | 1 | Pixel-clock enable, one reference cycle wide |
| interlace_o | output | 1 | Interlace flag |
| start_addr_hi_o | output | 4 | Display start-address bits 23:20 |

## Verification
The assertions assume that every selectable frequency is below half the reference frequency. Under that condition an accumulator overflow can never occur on two consecutive cycles, which the no-double-pulse properties rely on. The bench keeps to this condition by using the default 250 MHz reference, against which the fastest code gives 80 MHz. Select and divider inputs are changed only on the falling edge and then held for a whole measurement window, so each rate count covers one steady setting after its boundary handover. The CRTC byte is driven with free random values, because the decode places no constraint on it.

// File: rtl/pclk_pkg.sv
// Package: shared constants and the frequency-to-increment computation.
// Assumes the reference frequency exceeds twice the fastest table entry.
package pclk_pkg;

    localparam int unsigned NUM_CLK = 8;
    localparam int unsigned SEL_W   = 3;
    localparam int unsigned ACC_W   = 32;

    // Nominal frequency of each select code, in kHz.
    function automatic longint unsigned clk_khz(input int unsigned code);
        case (code)
            0:       clk_khz = 64'd25175;
            1:       clk_khz = 64'd28322;
            2:       clk_khz = 64'd36000;
            3:       clk_khz = 64'd65100;
            4:       clk_khz = 64'd44900;
            5:       clk_khz = 64'd50000;
            6:       clk_khz = 64'd80000;
            default: clk_khz = 64'd75000;
        endcase
    endfunction

    // Rounded phase increment: f * 2^ACC_W / ref.
    function automatic logic [ACC_W-1:0] inc_for(input int unsigned code,
                                                 input longint unsigned ref_hz);
        longint unsigned num;
        num = clk_khz(code) * 64'd1000 * (64'd1 << ACC_W) + ref_hz / 2;
        inc_for = ACC_W'(num / ref_hz);
    endfunction

endpackage

// File: rtl/pclk_phase_acc.sv
// Module: fractional phase accumulator producing an undivided enable.
// Emits a one-cycle tick on each accumulator overflow. The increment for
// a new select code is adopted only on an overflow cycle. Assumes every
// increment is below half of full scale.
module pclk_phase_acc #(
    parameter longint unsigned REF_HZ = 250_000_000,
    parameter int unsigned     SEL_W  = pclk_pkg::SEL_W,
    parameter int unsigned     ACC_W  = pclk_pkg::ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int unsigned NSEL = 1 << SEL_W;

    logic [ACC_W-1:0] inc_lut [NSEL];
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] inc_q;
    logic [ACC_W:0]   sum;

    // Constant increment table, one entry per select code.
    for (genvar g = 0; g < NSEL; g++) begin : g_lut
        assign inc_lut[g] = pclk_pkg::inc_for(g, REF_HZ);
    end

    // Next accumulator value with carry out.
    always_comb sum = {1'b0, acc_q} + {1'b0, inc_q};

    // Advance phase, flag overflow, adopt a new increment at overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            tick_o <= 1'b0;
            inc_q  <= inc_lut[sel_i];
        end else begin
            acc_q  <= sum[ACC_W-1:0];
            tick_o <= sum[ACC_W];
            if (sum[ACC_W]) inc_q <= inc_lut[sel_i];
        end
    end

    // R6: the increment only changes at an overflow boundary.
    p_inc_at_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(inc_q) |-> tick_o);

    // R6: overflow never repeats on back-to-back cycles.
    p_no_double_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/pclk_post_div.sv
// Module: post-divider by 1, 1.5, 2 or 4 on an enable stream.
// Counts input enables in groups of 1, 3, 2 or 4 and passes the first
// (or, for 1.5, the first two) of each group. A new code is adopted when
// a group completes. The output is registered.
module pclk_post_div #(
    parameter int unsigned CNT_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [1:0] div_code_i,
    output logic       en_o
);
    logic [1:0]       div_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic             pass;

    // Last count index of the current group and the pass decision.
    always_comb begin
        case (div_q)
            2'd0:    last = CNT_W'(0);
            2'd1:    last = CNT_W'(2);
            2'd2:    last = CNT_W'(1);
            default: last = CNT_W'(3);
        endcase
        pass = (div_q == 2'd1) ? (cnt_q != CNT_W'(2)) : (cnt_q == '0);
    end

    // Step the group counter and swap the code at a group boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            div_q <= div_code_i;
            en_o  <= 1'b0;
        end else begin
            en_o <= en_i & pass;
            if (en_i) begin
                if (cnt_q == last) begin
                    cnt_q <= '0;
                    div_q <= div_code_i;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R4: an output enable always follows an input enable.
    p_out_needs_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |-> $past(en_i));

    // R6: the divider code only changes on an input enable cycle.
    p_div_at_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_q) |-> $past(en_i));

    // R6: no back-to-back output enables.
    p_no_double_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |=> !en_o);

endmodule

// File: rtl/pclk_crtc_ext.sv
// Module: registered decode of the extended CRTC byte.
// Bit 0 selects interlace; bits 4 and 6 feed start-address bits 20 and 23.
module pclk_crtc_ext (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] crtc_ext_i,
    output logic       interlace_o,
    output logic [3:0] start_hi_o
);
    // Sample the flag and the address bits once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            interlace_o <= 1'b0;
            start_hi_o  <= '0;
        end else begin
            interlace_o <= crtc_ext_i[0];
            start_hi_o  <= {crtc_ext_i[6], 2'b00, crtc_ext_i[4]};
        end
    end

    // R7: interlace follows byte bit 0 with one cycle of latency.
    p_interlace_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (interlace_o == $past(crtc_ext_i[0])));

    // R8: address bit 23 follows byte bit 6 with one cycle of latency.
    p_addr23_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (start_hi_o[3] == $past(crtc_ext_i[6])));

endmodule

// File: rtl/pclk_gen_top.sv
// Top: pixel-clock enable generator with the extended CRTC decode.
// Joins the split select code, runs the accumulator and the post-divider,
// and decodes the CRTC byte. All state uses a synchronous active-low reset.
module pclk_gen_top #(
    parameter longint unsigned REF_HZ = 250_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] misc_clk_sel_i,
    input  logic       ext_clk_sel_i,
    input  logic [1:0] div_code_i,
    input  logic [7:0] crtc_ext_i,
    output logic       pix_en_o,
    output logic       interlace_o,
    output logic [3:0] start_addr_hi_o
);
    localparam int unsigned SEL_W = pclk_pkg::SEL_W;

    logic [SEL_W-1:0] sel;
    logic             raw_tick;

    // R1: high select bit from the extended register, low bits from misc.
    always_comb sel = {ext_clk_sel_i, misc_clk_sel_i};

    pclk_phase_acc #(.REF_HZ(REF_HZ)) acc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel),
        .tick_o (raw_tick)
    );

    pclk_post_div div_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (raw_tick),
        .div_code_i (div_code_i),
        .en_o       (pix_en_o)
    );

    pclk_crtc_ext crtc_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .crtc_ext_i  (crtc_ext_i),
        .interlace_o (interlace_o),
        .start_hi_o  (start_addr_hi_o)
    );

    // R9: after a reset edge all outputs are quiet.
    p_reset_quiet_r9: assert property (@(posedge clk)
        !$past(rst_n) && $past(rst_n, 2) == 1'b0 |->
        (!pix_en_o && !interlace_o && start_addr_hi_o == 4'd0));

endmodule

// File: tb/pclk_gen_top_tb_top.sv
module pclk_gen_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] misc_clk_sel_i = '0;
    logic       ext_clk_sel_i = 1'b0;
    logic [1:0] div_code_i = '0;
    logic [7:0] crtc_ext_i = '0;
    logic       pix_en_o, interlace_o;
    logic [3:0] start_addr_hi_o;

    int checks = 0;
    int errors = 0;
    localparam int WIN = 4000;

    always #2 clk = ~clk;

    pclk_gen_top dut_i (.*);

    function automatic real exp_khz(input int code);
        case (code)
            0: return 25175.0;  1: return 28322.0;
            2: return 36000.0;  3: return 65100.0;
            4: return 44900.0;  5: return 50000.0;
            6: return 80000.0;  default: return 75000.0;
        endcase
    endfunction

    function automatic real exp_div(input int dc);
        case (dc)
            0: return 1.0;  1: return 1.5;  2: return 2.0;  default: return 4.0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %f expected %f", req, what, act, exp);
        end
    endtask

    // Apply a setting, let it settle, count enables over a window.
    task automatic measure(input int code, input int dc);
        int cnt = 0;
        int dbl = 0;
        bit prev = 1'b0;
        real ideal;
        @(negedge clk);
        misc_clk_sel_i = code[1:0];
        ext_clk_sel_i  = code[2];
        div_code_i     = dc[1:0];
        repeat (64) @(negedge clk);
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (pix_en_o) cnt++;
            if (pix_en_o && prev) dbl++;
            prev = pix_en_o;
        end
        ideal = WIN * exp_khz(code) / 250000.0 / exp_div(dc);
        check((cnt - ideal <= 2.0) && (ideal - cnt <= 2.0),
              code < 2 ? (dc == 1 ? "R1 R3 R5" : "R1 R3 R4")
                       : (dc == 1 ? "R1 R2 R5" : "R1 R2 R4"),
              $sformatf("rate code %0d div %0d", code, dc), cnt, ideal);
        check(dbl == 0, "R6", "back-to-back enables", dbl, 0);
    endtask

    task automatic crtc_check(input logic [7:0] v);
        @(negedge clk);
        crtc_ext_i = v;
        @(negedge clk);
        check(interlace_o == v[0], "R7", "interlace", interlace_o, v[0]);
        check(start_addr_hi_o == {v[6], 2'b00, v[4]}, "R8", "start hi",
              start_addr_hi_o, {v[6], 2'b00, v[4]});
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int seed;
        seed = $urandom(32'h1f2e3d4c);
        crtc_ext_i = 8'hff;
        repeat (4) @(negedge clk);
        check(!pix_en_o && !interlace_o && start_addr_hi_o == 0, "R9",
              "reset outputs", {pix_en_o, interlace_o, start_addr_hi_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corners: fastest undivided, slowest quartered, 1.5 split,
        // and codes differing only in the extended select bit.
        measure(6, 0);
        measure(0, 3);
        measure(3, 1);
        measure(1, 0);
        measure(5, 0);
        measure(2, 2);
        measure(7, 1);
        measure(4, 3);

        // Random settings.
        for (int k = 0; k < 14; k++) begin
            int c, d;
            c = $urandom_range(7, 0);
            d = $urandom_range(3, 0);
            measure(c, d);
        end

        // CRTC decode: directed then random bytes.
        crtc_check(8'h51);
        crtc_check(8'h00);
        crtc_check(8'hae);
        for (int k = 0; k < 8; k++) crtc_check(8'($urandom));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule